// File: doc/BRIEF.md
# Interlaced Field Timing Generator

This block produces the field-rate and composite timing for a 441-line raster with 2:1 interlace at 50 Hz. A half-line counter advances on a one-cycle tick that arrives at twice the line rate. It steps through 441 states per field, so each field holds an odd number of half-lines and successive fields interleave. The vertical pulses (field sync, field blanking and a wider drive window) are decoded from this counter.

The block also forms composite sync and composite blanking. To do this it combines its own vertical state with the horizontal sync, horizontal blanking and the position within the current line. Those come from a separate line timing block. The field sync interval is made of eight serrated broad pulses, one per half-line. An enable input can add four narrow equalizing pulses before the broad pulses and four after them. When that input is low, those half-lines carry the ordinary line sync.

Top module: `fieldTimingGen`

## Requirements
- R1: The half-line state advances by one on every cycle with `halfTick` high. After state 440 it returns to 0, so 441 ticks bring the field back to the same state. With no tick and no restart, the vertical outputs hold their values.
- R2: `vReset` high forces the state to 0 at the next clock edge. It takes priority over a simultaneous `halfTick`.
- R3: `vBlank` is high exactly in states 0 to 57 (29 lines).
- R4: `vSync` is high exactly in states 4 to 11 (the eight broad-pulse half-lines).
- R5: `vDrive` is high exactly in states 0 to 15.
- R6: In states 4 to 11, `compSync` is high when the half-line slot (`slotPos[6:0]`) is below 102 and low from 102 to 127. `hSync` has no effect there.
- R7: With `eqEnable` high, in states 0 to 3 and 12 to 15, `compSync` is high when the half-line slot is below 13 and low otherwise. `hSync` has no effect there.
- R8: With `eqEnable` low, in states 0 to 3 and 12 to 15, `compSync` equals `hSync`.
- R9: In states 16 to 440, `compSync` equals `hSync`.
- R10: `compBlank` is the OR of `hBlank` and `vBlank`.
- R11: After reset (`rstN` low), the state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Element clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | One-cycle advance strobe at twice the line rate |
| slotPos | input | 8 | Slot position within the current line (0..255, 128 per half-line) |
| hSync | input | 1 | Line sync, active high |
| hBlank | input | 1 | Line blanking, active high |
| vReset | input | 1 | Field restart, forces state 0 |
| eqEnable | input | 1 | Enables the equalizing pulses around field sync |
| vSync | output | 1 | Field sync, active high |
| vBlank | output | 1 | Field blanking, active high |
| vDrive | output | 1 | Field drive window, active high |
| compSync | output | 1 | Composite sync, active high |
| compBlank | output | 1 | Composite blanking, active high |

## Verification
The assertions assume that `halfTick` is a single-cycle strobe and that `slotPos` follows the line and half-line position without gaps. They also assume that `vReset` and `halfTick` are the only events that move the vertical state. The stable-output property depends on no advance happening without a tick. The bench drives every input on the falling clock edge and raises `halfTick` for exactly one cycle per step. It holds `slotPos`, `hSync` and `hBlank` steady while it samples, so each comparison sees one settled half-line state.

// File: rtl/fieldTimingPkg.sv
package fieldTimingPkg;
  typedef struct packed {
    logic clear;
    logic incr;
  } ctrlStrobes_t;
endpackage

// File: rtl/fieldCtrl.sv
module fieldCtrl
  import fieldTimingPkg::*;
(
  input  logic halfTick,
  input  logic vReset,
  input  logic atLast,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clear = vReset | (halfTick & atLast);
    strobes.incr  = halfTick & ~vReset & ~atLast;
  end
endmodule

// File: rtl/fieldDatapath.sv
module fieldDatapath
  import fieldTimingPkg::*;
#(
  parameter int HALF_LINES   = 441,
  parameter int SLOT_W       = 8,
  parameter int EQ_COUNT     = 4,
  parameter int BROAD_COUNT  = 8,
  parameter int BLANK_HALVES = 58,
  parameter int BROAD_LOW    = 102,
  parameter int EQ_WIDTH     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SLOT_W-1:0] slotPos,
  input  logic              hSync,
  input  logic              hBlank,
  input  logic              eqEnable,
  output logic              atLast,
  output logic              vSync,
  output logic              vBlank,
  output logic              vDrive,
  output logic              compSync,
  output logic              compBlank
);
  localparam int CNT_W      = $clog2(HALF_LINES);
  localparam int HS_W       = SLOT_W - 1;
  localparam int BROAD_FIRST = EQ_COUNT;
  localparam int BROAD_LAST  = EQ_COUNT + BROAD_COUNT - 1;
  localparam int DRIVE_LAST  = 2 * EQ_COUNT + BROAD_COUNT - 1;

  logic [CNT_W-1:0] halfIdx;
  logic [HS_W-1:0]  halfSlot;
  logic             inBroad;
  logic             inEqZone;
  logic             broadPulse;
  logic             eqPulse;

  always_ff @(posedge clk) begin
    if (!rstN)              halfIdx <= '0;
    else if (strobes.clear) halfIdx <= '0;
    else if (strobes.incr)  halfIdx <= halfIdx + 1'b1;
  end

  assign atLast   = (halfIdx == CNT_W'(HALF_LINES - 1));
  assign halfSlot = slotPos[HS_W-1:0];

  always_comb begin
    inBroad    = (halfIdx >= CNT_W'(BROAD_FIRST)) && (halfIdx <= CNT_W'(BROAD_LAST));
    vDrive     = (halfIdx <= CNT_W'(DRIVE_LAST));
    vBlank     = (halfIdx <= CNT_W'(BLANK_HALVES - 1));
    vSync      = inBroad;
    inEqZone   = vDrive && !inBroad;
    broadPulse = (halfSlot < HS_W'(BROAD_LOW));
    eqPulse    = (halfSlot < HS_W'(EQ_WIDTH));
  end

  always_comb begin
    if (inBroad)                   compSync = broadPulse;
    else if (inEqZone && eqEnable) compSync = eqPulse;
    else                           compSync = hSync;
    compBlank = hBlank | vBlank;
  end
endmodule

// File: rtl/fieldTimingGen.sv
module fieldTimingGen
  import fieldTimingPkg::*;
#(
  parameter int HALF_LINES   = 441,
  parameter int SLOT_W       = 8,
  parameter int EQ_COUNT     = 4,
  parameter int BROAD_COUNT  = 8,
  parameter int BLANK_HALVES = 58,
  parameter int BROAD_LOW    = 102,
  parameter int EQ_WIDTH     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic [SLOT_W-1:0] slotPos,
  input  logic              hSync,
  input  logic              hBlank,
  input  logic              vReset,
  input  logic              eqEnable,
  output logic              vSync,
  output logic              vBlank,
  output logic              vDrive,
  output logic              compSync,
  output logic              compBlank
);
  ctrlStrobes_t strobes;
  logic         atLast;

  fieldCtrl u_ctrl (
    .halfTick (halfTick),
    .vReset   (vReset),
    .atLast   (atLast),
    .strobes  (strobes)
  );

  fieldDatapath #(
    .HALF_LINES   (HALF_LINES),
    .SLOT_W       (SLOT_W),
    .EQ_COUNT     (EQ_COUNT),
    .BROAD_COUNT  (BROAD_COUNT),
    .BLANK_HALVES (BLANK_HALVES),
    .BROAD_LOW    (BROAD_LOW),
    .EQ_WIDTH     (EQ_WIDTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .slotPos   (slotPos),
    .hSync     (hSync),
    .hBlank    (hBlank),
    .eqEnable  (eqEnable),
    .atLast    (atLast),
    .vSync     (vSync),
    .vBlank    (vBlank),
    .vDrive    (vDrive),
    .compSync  (compSync),
    .compBlank (compBlank)
  );
endmodule

// File: rtl/fieldTimingChecker.sv
module fieldTimingChecker #(
  parameter int SLOT_W    = 8,
  parameter int BROAD_LOW = 102
) (
  input logic              clk,
  input logic              rstN,
  input logic              halfTick,
  input logic              vReset,
  input logic [SLOT_W-1:0] slotPos,
  input logic              hSync,
  input logic              hBlank,
  input logic              vSync,
  input logic              vBlank,
  input logic              vDrive,
  input logic              compSync,
  input logic              compBlank
);
  localparam int HS_W = SLOT_W - 1;
  logic lowBroadSlot;
  assign lowBroadSlot = (slotPos[HS_W-1:0] < HS_W'(BROAD_LOW));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!halfTick && !vReset) |=> ($stable(vSync) && $stable(vBlank) && $stable(vDrive)));

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    vReset |=> (vDrive && vBlank && !vSync));

  assert_drive_in_blank_R3: assert property (@(posedge clk) disable iff (!rstN)
    vDrive |-> vBlank);

  assert_sync_in_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> vDrive);

  assert_broad_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vSync && lowBroadSlot) |-> compSync);

  assert_outside_R9: assert property (@(posedge clk) disable iff (!rstN)
    !vDrive |-> (compSync == hSync));

  assert_hblank_R10: assert property (@(posedge clk) disable iff (!rstN)
    hBlank |-> compBlank);
endmodule

bind fieldTimingGen fieldTimingChecker #(.SLOT_W(SLOT_W), .BROAD_LOW(BROAD_LOW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .halfTick  (halfTick),
  .vReset    (vReset),
  .slotPos   (slotPos),
  .hSync     (hSync),
  .hBlank    (hBlank),
  .vSync     (vSync),
  .vBlank    (vBlank),
  .vDrive    (vDrive),
  .compSync  (compSync),
  .compBlank (compBlank)
);

// File: tb/fieldTimingGen_bench.sv
module fieldTimingGen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic [7:0] slotPos = 8'd0;
  logic       hSync = 1'b0;
  logic       hBlank = 1'b0;
  logic       vReset = 1'b0;
  logic       eqEnable = 1'b0;
  logic       vSync, vBlank, vDrive, compSync, compBlank;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fieldTimingGen u_fieldTimingGen (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .slotPos(slotPos),
    .hSync(hSync), .hBlank(hBlank), .vReset(vReset), .eqEnable(eqEnable),
    .vSync(vSync), .vBlank(vBlank), .vDrive(vDrive),
    .compSync(compSync), .compBlank(compBlank)
  );

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s state=%0d slot=%0d: got %b expected %b", tag, what, idx, slotPos, got, exp);
    end
  endtask

  function automatic logic expSync();
    int hs = slotPos[6:0];
    if (idx >= 4 && idx <= 11) return hs < 102;
    if (idx <= 15 && eqEnable) return hs < 13;
    return hSync;
  endfunction

  task automatic checkAll(input string tag);
    check(tag, "vSync", vSync, idx >= 4 && idx <= 11);
    check(tag, "vBlank", vBlank, idx <= 57);
    check(tag, "vDrive", vDrive, idx <= 15);
    check(tag, "compSync", compSync, expSync());
    check(tag, "compBlank", compBlank, hBlank | (idx <= 57));
  endtask

  task automatic step();
    @(negedge clk) halfTick = 1'b1;
    @(negedge clk) halfTick = 1'b0;
    idx = (idx == 440) ? 0 : idx + 1;
  endtask

  task automatic goTo(input int target);
    while (idx != target) step();
  endtask

  task automatic testReset();
    checkAll("R11");
  endtask

  task automatic testSweep();
    for (int i = 0; i < 441; i++) begin
      step();
      slotPos = 8'(i * 37);
      hSync = i[0];
      #0.5;
      checkAll("R1");
    end
    check("R1", "wrap vBlank", vBlank, 1'b1);
    repeat (5) @(negedge clk);
    checkAll("R1");
  endtask

  task automatic testBroad();
    goTo(5);
    foreach (slotPos[i]) ;
    for (int h = 0; h < 2; h++) begin
      hSync = h[0];
      slotPos = 8'd0;   #0.5; check("R6", "broad slot0", compSync, 1'b1);
      slotPos = 8'd101; #0.5; check("R6", "broad slot101", compSync, 1'b1);
      slotPos = 8'd102; #0.5; check("R6", "broad slot102", compSync, 1'b0);
      slotPos = 8'd127; #0.5; check("R6", "broad slot127", compSync, 1'b0);
      slotPos = 8'd178; #0.5; check("R6", "broad slot178", compSync, 1'b1);
      slotPos = 8'd240; #0.5; check("R4", "vSync", vSync, 1'b1);
    end
  endtask

  task automatic testEq();
    goTo(13);
    for (int e = 0; e < 2; e++) begin
      eqEnable = e[0];
      for (int h = 0; h < 2; h++) begin
        hSync = h[0];
        slotPos = 8'd12;  #0.5; check(e ? "R7" : "R8", "eq slot12", compSync, e ? 1'b1 : h[0]);
        slotPos = 8'd13;  #0.5; check(e ? "R7" : "R8", "eq slot13", compSync, e ? 1'b0 : h[0]);
        slotPos = 8'd130; #0.5; check(e ? "R7" : "R8", "eq slot130", compSync, e ? 1'b1 : h[0]);
      end
    end
    eqEnable = 1'b0;
    check("R5", "vDrive at 13", vDrive, 1'b1);
  endtask

  task automatic testOutside();
    eqEnable = 1'b1;
    goTo(16);
    for (int h = 0; h < 2; h++) begin
      hSync = h[0];
      slotPos = 8'd5; #0.5;
      check("R9", "compSync state16", compSync, h[0]);
      check("R5", "vDrive state16", vDrive, 1'b0);
    end
    eqEnable = 1'b0;
  endtask

  task automatic testBlank();
    goTo(57);
    for (int h = 0; h < 2; h++) begin
      hBlank = h[0]; #0.5;
      check("R10", "compBlank state57", compBlank, 1'b1);
    end
    step();
    for (int h = 0; h < 2; h++) begin
      hBlank = h[0]; #0.5;
      check("R10", "compBlank state58", compBlank, h[0]);
      check("R3", "vBlank state58", vBlank, 1'b0);
    end
    hBlank = 1'b0;
  endtask

  task automatic testVReset();
    goTo(200);
    @(negedge clk) begin vReset = 1'b1; halfTick = 1'b1; end
    @(negedge clk) begin vReset = 1'b0; halfTick = 1'b0; end
    idx = 0;
    checkAll("R2");
    goTo(30);
    @(negedge clk) vReset = 1'b1;
    @(negedge clk) vReset = 1'b0;
    idx = 0;
    checkAll("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSweep();
    testBroad();
    testEq();
    testOutside();
    testBlank();
    testVReset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule